// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer whose control register accepts a new configuration only after a two-write unlock sequence. The first write must be an exact key word. The second write carries a second key tag together with the configuration: enable, power, prescaler select and a 16-bit reload value. Software services the watchdog by repeating the whole sequence, which reloads the count and restarts the prescaler. If the countdown runs out, the block raises a one-clock reset request and sets a sticky reset-cause flag. That flag survives the system reset the request triggers and is cleared only by the power-on reset.

Two state machines make up the block. The key sequencer has the states LOCKED and ARMED. A control write of exactly 0x00BE0000 moves LOCKED to ARMED (arm). In ARMED, a control write whose bits 23:16 equal 0xDC applies the configuration and returns to LOCKED (accept). Any other control write in ARMED returns to LOCKED and is dropped (abort). The countdown machine has the states OFF, HOLD, RUN and FIRE. An accepted configuration with enable clear goes to OFF (stop). With enable set and power 2'b11 it goes to RUN (start). With enable set and any other power value it goes to HOLD (park). In RUN, a prescaled tick that finds the count at 1 or 0 moves to FIRE (expire). FIRE always returns to OFF on the next clock (retire). An accepted configuration overrides every other transition.

A prescaler divides the clock by one of four parameter values chosen by the select field. The status register shows the running state, the cause flag, the select field and the live count.

Top module: `keyed_watchdog`

## Requirements
- R1: After rst_n and por_n are released, the status word reads 0 and rst_req and rst_cause are 0.
- R2: A control write (offset 0x0) of exactly 0x00BE0000, followed by a control write with bits 23:16 = 0xDC, applies that second word's fields: enable in bit 31, power in bits 27:26, select in bits 25:24 and reload in bits 15:0. The new values read back on the clock edge that samples the second write.
- R3: A control write that does not follow the first key is ignored. A control write after the first key whose bits 23:16 are not 0xDC, including a repeat of the first key, is ignored and cancels the sequence, so a fresh first key is needed. Writes to other offsets neither configure the block nor disturb the sequence.
- R4: Reading offset 0x8 gives bit 31 = enabled (HOLD or RUN), bit 30 = reset cause, bits 25:24 = select, bits 15:0 = count, with every other bit 0. Reading offset 0x0 gives 0.
- R5: In RUN the count drops by one every D clocks, where D is DIV0, DIV1, DIV2 or DIV3 for select 0, 1, 2 or 3. DIV3 defaults to 0x40000. The first decrement comes D clocks after the accepting edge.
- R6: With enable set and power not equal to 2'b11, the count holds at the reload value and no reset request is raised.
- R7: With reload N ≥ 1, rst_req is high for exactly one clock, starting N·D clocks after the accepting edge. The count then reads 0 and enabled reads 0. A reload of 0 expires like a reload of 1.
- R8: rst_cause is set on the edge that raises rst_req. It stays set through rst_n and is cleared only by por_n.
- R9: Repeating the full sequence with enable set before expiry reloads the count and restarts the prescaler, so no reset request is raised while the watchdog is serviced.
- R10: An accepted second write with enable clear stops the countdown and never raises a reset request. With all fields zero (0x00DC0000) the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the reset-cause flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears everything except the cause flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| rst_req | output | 1 | One-clock reset request on expiry |
| rst_cause | output | 1 | Sticky flag: the last reset request came from the watchdog |

## Verification
The bench builds the block with the four dividers set to 2, 3, 4 and 8 instead of the default top value of 0x40000. Expiry, the decrement rate for every select value and repeated keep-alive servicing therefore play out within tens of clocks. This lets the exact cycle of each decrement and of the reset pulse be checked for all four select values. It also makes reload values as small as 0 and 1 reachable in the same run as the abort, hold and disable cases.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned RELOAD_W = 16;

    localparam logic [7:0] KEY1_TAG = 8'hBE;
    localparam logic [7:0] KEY2_TAG = 8'hDC;
    localparam logic [1:0] PWR_ON   = 2'b11;

    typedef enum logic {
        KS_LOCKED,
        KS_ARMED
    } ks_state_t;

    typedef enum logic [1:0] {
        CS_OFF,
        CS_HOLD,
        CS_RUN,
        CS_FIRE
    } cs_state_t;

    typedef struct packed {
        logic                en;
        logic [1:0]          pwr;
        logic [1:0]          sel;
        logic [RELOAD_W-1:0] reload;
    } wdk_cfg_t;

endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic             armed,
    output logic             cfg_load,
    output wdk_cfg_t         cfg
);

    localparam logic [REG_W-1:0] KEY1_WORD = {8'h00, KEY1_TAG, 16'h0000};

    ks_state_t state_q;
    ks_state_t state_d;
    logic      is_key1;
    logic      is_key2;

    assign is_key1 = (wr_data == KEY1_WORD);
    assign is_key2 = (wr_data[23:16] == KEY2_TAG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, accept, abort
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case (state_q)
                KS_LOCKED: state_d = is_key1 ? KS_ARMED : KS_LOCKED;
                KS_ARMED:  state_d = KS_LOCKED;
                default:   state_d = KS_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        armed      = (state_q == KS_ARMED);
        cfg_load   = ctrl_wr && (state_q == KS_ARMED) && is_key2;
        cfg.en     = wr_data[31];
        cfg.pwr    = wr_data[27:26];
        cfg.sel    = wr_data[25:24];
        cfg.reload = wr_data[RELOAD_W-1:0];
    end

endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
    parameter int unsigned DIV0 = 32'h40,
    parameter int unsigned DIV1 = 32'h400,
    parameter int unsigned DIV2 = 32'h4000,
    parameter int unsigned DIV3 = 32'h40000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    function automatic int unsigned div_of(input int idx);
        case (idx)
            0:       return DIV0;
            1:       return DIV1;
            2:       return DIV2;
            default: return DIV3;
        endcase
    endfunction

    function automatic int unsigned max_div();
        int unsigned m;
        m = DIV0;
        if (DIV1 > m) m = DIV1;
        if (DIV2 > m) m = DIV2;
        if (DIV3 > m) m = DIV3;
        return m;
    endfunction

    localparam int unsigned MAXD  = max_div();
    localparam int          PRE_W = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [PRE_W-1:0] lim [4];
    logic [PRE_W-1:0] pcnt_q;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim[g] = PRE_W'(div_of(g) - 1);
    end

    assign tick = run && (pcnt_q == lim[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clear) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown
    import wdk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  wdk_cfg_t            cfg,
    input  logic                tick,
    output logic                run,
    output logic                enabled,
    output logic                expire,
    output logic                rst_req,
    output logic [RELOAD_W-1:0] cnt,
    output logic [1:0]          sel
);

    localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

    cs_state_t           st_q;
    cs_state_t           st_d;
    logic [RELOAD_W-1:0] cnt_q;
    logic [1:0]          sel_q;
    logic                last;

    assign last = (cnt_q <= ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CS_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: stop, start, park, expire, retire
    always_comb begin
        st_d = st_q;
        if (load) begin
            if (!cfg.en) begin
                st_d = CS_OFF;
            end else if (cfg.pwr == PWR_ON) begin
                st_d = CS_RUN;
            end else begin
                st_d = CS_HOLD;
            end
        end else begin
            unique case (st_q)
                CS_OFF:  st_d = CS_OFF;
                CS_HOLD: st_d = CS_HOLD;
                CS_RUN:  st_d = (tick && last) ? CS_FIRE : CS_RUN;
                CS_FIRE: st_d = CS_OFF;
                default: st_d = CS_OFF;
            endcase
        end
    end

    // datapath: count and selected prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (load) begin
            cnt_q <= cfg.reload;
            sel_q <= cfg.sel;
        end else if ((st_q == CS_RUN) && tick) begin
            cnt_q <= last ? '0 : cnt_q - ONE;
        end
    end

    // outputs
    always_comb begin
        run     = (st_q == CS_RUN);
        enabled = (st_q == CS_RUN) || (st_q == CS_HOLD);
        rst_req = (st_q == CS_FIRE);
        expire  = (st_q == CS_RUN) && tick && last && !load;
        cnt     = cnt_q;
        sel     = sel_q;
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTRL_OFS = 0,
    parameter int unsigned STAT_OFS = 8,
    parameter int unsigned DIV0     = 32'h40,
    parameter int unsigned DIV1     = 32'h400,
    parameter int unsigned DIV2     = 32'h4000,
    parameter int unsigned DIV3     = 32'h40000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              rst_req,
    output logic              rst_cause
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic                ctrl_wr;
    logic                armed;
    logic                cfg_load;
    wdk_cfg_t            cfg;
    logic                tick;
    logic                run;
    logic                enabled;
    logic                expire;
    logic [RELOAD_W-1:0] cnt;
    logic [1:0]          div_sel;
    logic                cause_q;

    assign ctrl_wr = wr_en && (wr_addr == CTRL_A);

    wdk_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wr_data  (wr_data),
        .armed    (armed),
        .cfg_load (cfg_load),
        .cfg      (cfg)
    );

    wdk_prescaler #(
        .DIV0 (DIV0),
        .DIV1 (DIV1),
        .DIV2 (DIV2),
        .DIV3 (DIV3)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_load),
        .run   (run),
        .sel   (div_sel),
        .tick  (tick)
    );

    wdk_countdown u_countdown (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .cfg     (cfg),
        .tick    (tick),
        .run     (run),
        .enabled (enabled),
        .expire  (expire),
        .rst_req (rst_req),
        .cnt     (cnt),
        .sel     (div_sel)
    );

    // reset-cause flag: only the power-on reset clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (expire) begin
            cause_q <= 1'b1;
        end
    end

    assign rst_cause = cause_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_A) begin
            rd_data = {enabled, cause_q, 4'b0000, div_sel, 8'h00, cnt};
        end
    end

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                por_n,
    input logic                rst_req,
    input logic                rst_cause,
    input logic                ctrl_wr,
    input logic                armed,
    input logic                cfg_load,
    input logic                run,
    input logic                tick,
    input logic [RELOAD_W-1:0] cnt,
    input logic [1:0]          div_sel
);

    // R7: the request lasts one clock
    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: the request comes only with the count at zero
    a_r7_req_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0));

    // R8: a request always leaves the cause flag set
    a_r8_req_sets_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> rst_cause);

    // R8: the cause flag is sticky until power-on reset
    a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        rst_cause |=> rst_cause);

    // R3: a control write while locked cannot change the prescaler select
    a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !armed) |=> $stable(div_sel));

    // R5: while running, the count never rises without a reload
    a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_load) |=> (cnt <= $past(cnt)));

    // R5: prescaler ticks only while running
    a_r5_tick_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R6: outside RUN the count is frozen unless reloaded
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cfg_load) |=> $stable(cnt));

endmodule

bind keyed_watchdog wdk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .rst_req   (rst_req),
    .rst_cause (rst_cause),
    .ctrl_wr   (ctrl_wr),
    .armed     (armed),
    .cfg_load  (cfg_load),
    .run       (run),
    .tick      (tick),
    .cnt       (cnt),
    .div_sel   (div_sel)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    localparam int unsigned AW = 4;
    localparam logic [31:0] KEY1 = 32'h00BE_0000;
    localparam logic [31:0] KEY2_OFF = 32'h00DC_0000;

    logic          clk = 1'b0;
    logic          por_n;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic          rst_req;
    logic          rst_cause;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(
        .ADDR_W (AW),
        .DIV0   (2),
        .DIV1   (3),
        .DIV2   (4),
        .DIV3   (8)
    ) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rst_req   (rst_req),
        .rst_cause (rst_cause)
    );

    always @(negedge clk) if (rst_req) pulses <= pulses + 1;

    function automatic logic [31:0] cfgw(input logic en, input logic [1:0] pwr,
                                         input logic [1:0] sel, input logic [15:0] rl);
        return {en, 3'b000, pwr, sel, 8'hDC, rl};
    endfunction

    function automatic logic [31:0] stat(input logic en, input logic cause,
                                         input logic [1:0] sel, input logic [15:0] c);
        return {en, cause, 4'b0000, sel, 8'h00, c};
    endfunction

    function automatic int div_of(input int s);
        case (s)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
    endtask

    task automatic unlock(input logic [31:0] d);
        wr(4'h0, KEY1);
        wr(4'h0, d);
    endtask

    task automatic full_reset();
        por_n = 1'b0;
        rst_n = 1'b0;
        idle(2);
        por_n = 1'b1;
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        chk("R1 status after reset", rd_data, 32'h0);
        chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
        chk("R1 rst_cause after reset", {31'b0, rst_cause}, 32'h0);
        rd_addr = 4'h0;
        #1;
        chk("R4 control offset reads zero", rd_data, 32'h0);
        rd_addr = 4'h8;
        idle(1);
    endtask

    task automatic t_dividers();
        for (int s = 0; s < 4; s++) begin
            int d;
            d = div_of(s);
            unlock(cfgw(1'b1, 2'b11, 2'(s), 16'd40));
            chk("R2 config applied", rd_data, stat(1'b1, 1'b0, 2'(s), 16'd40));
            idle(d - 1);
            chk("R5 no decrement before D clocks", rd_data, stat(1'b1, 1'b0, 2'(s), 16'd40));
            idle(1);
            chk("R5 first decrement at D clocks", rd_data, stat(1'b1, 1'b0, 2'(s), 16'd39));
            idle(d);
            chk("R5 second decrement", rd_data, stat(1'b1, 1'b0, 2'(s), 16'd38));
            unlock(KEY2_OFF);
            chk("R10 all-zero config reads zero", rd_data, 32'h0);
        end
    endtask

    task automatic t_abort();
        wr(4'h0, cfgw(1'b1, 2'b11, 2'd1, 16'd9));
        chk("R3 second key without first ignored", rd_data, 32'h0);
        wr(4'h0, KEY1);
        wr(4'h0, 32'h00AA_0000);
        wr(4'h0, cfgw(1'b1, 2'b11, 2'd1, 16'd9));
        chk("R3 wrong tag aborts sequence", rd_data, 32'h0);
        wr(4'h0, KEY1);
        wr(4'h0, KEY1);
        wr(4'h0, cfgw(1'b1, 2'b11, 2'd1, 16'd9));
        chk("R3 repeated first key aborts", rd_data, 32'h0);
        wr(4'h0, 32'h00BE_0001);
        wr(4'h0, cfgw(1'b1, 2'b11, 2'd1, 16'd9));
        chk("R3 inexact first key not accepted", rd_data, 32'h0);
        wr(4'h0, KEY1);
        wr(4'h8, cfgw(1'b1, 2'b11, 2'd3, 16'd77));
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h0, cfgw(1'b1, 2'b01, 2'd2, 16'h0123));
        chk("R3 other offsets keep sequence", rd_data, stat(1'b1, 1'b0, 2'd2, 16'h0123));
        unlock(KEY2_OFF);
    endtask

    task automatic t_hold();
        int p0;
        p0 = pulses;
        unlock(cfgw(1'b1, 2'b01, 2'd0, 16'd7));
        idle(40);
        chk("R6 power 01 holds count", rd_data, stat(1'b1, 1'b0, 2'd0, 16'd7));
        unlock(cfgw(1'b1, 2'b10, 2'd0, 16'd3));
        idle(40);
        chk("R6 power 10 holds count", rd_data, stat(1'b1, 1'b0, 2'd0, 16'd3));
        chk("R6 no reset while held", pulses, p0);
        unlock(KEY2_OFF);
    endtask

    task automatic t_expiry();
        int p0;
        p0 = pulses;
        unlock(cfgw(1'b1, 2'b11, 2'd1, 16'd5));
        idle(14);
        chk("R7 no request before N*D", {31'b0, rst_req}, 32'h0);
        chk("R7 count one before expiry", rd_data, stat(1'b1, 1'b0, 2'd1, 16'd1));
        idle(1);
        chk("R7 request at N*D", {31'b0, rst_req}, 32'h1);
        chk("R8 cause set with request", rd_data, stat(1'b0, 1'b1, 2'd1, 16'd0));
        idle(1);
        chk("R7 request lasts one clock", {31'b0, rst_req}, 32'h0);
        chk("R7 single pulse", pulses, p0 + 1);
        chk("R7 off after expiry", rd_data, stat(1'b0, 1'b1, 2'd1, 16'd0));
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk("R8 cause survives system reset", rd_data, stat(1'b0, 1'b1, 2'd0, 16'd0));
        unlock(cfgw(1'b1, 2'b11, 2'd3, 16'd0));
        idle(7);
        chk("R7 reload zero no early request", {31'b0, rst_req}, 32'h0);
        idle(1);
        chk("R7 reload zero expires like one", {31'b0, rst_req}, 32'h1);
        idle(1);
        por_n = 1'b0;
        idle(1);
        por_n = 1'b1;
        idle(1);
        chk("R8 power-on reset clears cause", {31'b0, rst_cause}, 32'h0);
    endtask

    task automatic t_keepalive();
        int p0;
        p0 = pulses;
        unlock(cfgw(1'b1, 2'b11, 2'd0, 16'd5));
        for (int i = 0; i < 6; i++) begin
            idle(5);
            unlock(cfgw(1'b1, 2'b11, 2'd0, 16'd5));
        end
        chk("R9 count reloaded by service", rd_data, stat(1'b1, 1'b0, 2'd0, 16'd5));
        chk("R9 no request while serviced", pulses, p0);
        idle(9);
        chk("R9 timer restarted at last service", {31'b0, rst_req}, 32'h0);
        idle(1);
        chk("R9 expiry after service stops", {31'b0, rst_req}, 32'h1);
        idle(1);
        full_reset();
    endtask

    task automatic t_disable();
        int p0;
        p0 = pulses;
        unlock(cfgw(1'b1, 2'b11, 2'd0, 16'd6));
        idle(3);
        unlock(KEY2_OFF);
        chk("R10 disable reads zero", rd_data, 32'h0);
        idle(30);
        chk("R10 still zero after wait", rd_data, 32'h0);
        unlock(cfgw(1'b0, 2'b11, 2'd2, 16'd9));
        idle(30);
        chk("R10 enable clear keeps count", rd_data, stat(1'b0, 1'b0, 2'd2, 16'd9));
        chk("R10 no request when disabled", pulses, p0);
    endtask

    initial begin
        por_n   = 1'b0;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = 4'h8;
        idle(3);
        por_n = 1'b1;
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_dividers();
        t_abort();
        t_hold();
        t_expiry();
        t_keepalive();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule